// File: doc/BRIEF.md
# Runt Clock Phase Detector

This block watches a clock that it does not run on. It samples the monitored clock with a much faster reference clock, measures every high phase and every low phase in reference ticks, and compares each finished phase with one programmable minimum width. The first phase that is too short raises a sticky violation flag. The block also records whether that phase was high or low and how long it lasted. It acts like an oscilloscope trigger that stops on a narrow pulse, but it is built into hardware.

A typical use is to check a clock-selection circuit. The minimum is set to half the period of the fastest clock the downstream logic accepts. For example, a 14 MHz part needs about 35 ns per phase, which is five ticks of an 8 ns reference. The monitor is then left running. If the flag is still low after any length of time, no runt phase occurred. The clear input drops the flag and arms the detector again.

Internally there are three stages. The first is a synchronizer chain. The second is a phase meter that spots level changes and counts ticks, saturating at its maximum. The third is a capture state machine with three states:

- `ST_WAIT_EDGE`: the length of the phase in progress is unknown.
- `ST_ARMED`: every completed phase is compared with the minimum.
- `ST_TRIPPED`: the first violation is frozen.

The state machine moves between these states as follows:

- Reset or clear returns it to `ST_WAIT_EDGE`.
- From `ST_WAIT_EDGE`, a detected level change moves it to `ST_ARMED`.
- From `ST_ARMED`, a completed phase shorter than the minimum moves it to `ST_TRIPPED`.
- `ST_TRIPPED` holds until clear.

Top module: `runt_pulse_monitor`

## Requirements
- R1: While reset is high, and after it, until a violation occurs, `runt_flag`, `runt_level` and `runt_len` are all zero. Reset is synchronous and active high.
- R2: The monitored clock passes through two reference-clock flip-flops. Suppose the rising reference edge at which the transition ending a short phase is first sampled is edge t. The violation outputs are then visible after edge t+2.
- R3: A completed high phase whose length (the number of rising reference edges that sampled it high) is below `min_ticks` trips the detector with `runt_level`=1 and `runt_len` equal to that length.
- R4: A completed low phase below `min_ticks` trips the detector with `runt_level`=0 and `runt_len` equal to its length.
- R5: The comparison is strictly less-than. A phase whose length equals `min_ticks` does not trip the detector. The value of `min_ticks` used is the one present when the phase ends.
- R6: The first phase after reset, and the phase in progress when clear is applied, are never checked.
- R7: Once tripped, the flag stays high and `runt_level`/`runt_len` keep the first violation, whatever phases follow, until clear.
- R8: With `clr` high at a rising reference edge, all three outputs are zero after that edge and the detector re-arms from the next level change. `clr` takes priority over a capture in the same cycle.
- R9: The phase counter saturates at 2^CNT_W-1, so phases longer than that never trip, even with `min_ticks` at its maximum. A phase of 2^CNT_W-2 ticks against that maximum does trip.
- R10: With `min_ticks` equal to zero, no phase ever trips the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock that samples the monitored clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored clock, asynchronous to ref_clk |
| min_ticks | input | CNT_W | Minimum allowed phase width in reference ticks |
| clr | input | 1 | Drops the flag and re-arms the detector |
| runt_flag | output | 1 | Sticky violation flag |
| runt_level | output | 1 | Level of the offending phase (1 = high) |
| runt_len | output | CNT_W | Measured length of the offending phase |

## Verification
The assertions check the following on every cycle:

- the flag stays high, and the captured level and length stay frozen, until clear;
- clear drops the flag one edge later;
- outputs are zero whenever the flag is low;
- any newly raised flag reports a non-zero length below the minimum that applied.

Only the bench scenarios can show the rest. This covers the exact two-edge synchronizer latency, the ignored first phase after reset and after clear, the strict boundary at a length equal to the minimum, and saturation on very long phases. The bench's cycle model covers all of these, because they depend on phase history rather than on neighbouring cycles.

// File: rtl/rpm_pkg.sv
`timescale 1ns/1ps
package rpm_pkg;

    // Capture state machine states
    typedef enum logic [1:0] {
        ST_WAIT_EDGE = 2'd0,   // phase start unknown, next change arms
        ST_ARMED     = 2'd1,   // each completed phase is compared
        ST_TRIPPED   = 2'd2    // first violation frozen until clear
    } rpm_state_e;

    // Report of a completed phase from the meter
    typedef struct packed {
        logic seen;    // a level change was detected this cycle
        logic level;   // level of the phase that just ended
    } phase_end_t;

endpackage

// File: rtl/rpm_sync.sv
`timescale 1ns/1ps
module rpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rpm_phase_meter.sv
`timescale 1ns/1ps
module rpm_phase_meter
    import rpm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    output phase_end_t       ev,
    output logic [CNT_W-1:0] run_len
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             prev_level;
    logic [CNT_W-1:0] ticks;

    assign ev.seen  = level ^ prev_level;
    assign ev.level = prev_level;
    assign run_len  = ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_level <= 1'b0;
            ticks      <= '0;
        end else begin
            prev_level <= level;
            if (ev.seen) begin
                ticks <= CNT_ONE;
            end else if (ticks != CNT_MAX) begin
                ticks <= ticks + CNT_ONE;
            end
        end
    end
endmodule

// File: rtl/rpm_capture_fsm.sv
`timescale 1ns/1ps
module rpm_capture_fsm
    import rpm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  phase_end_t       ev,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] thresh,
    output logic             flag,
    output logic             level,
    output logic [CNT_W-1:0] len
);
    rpm_state_e state, state_nxt;
    logic       short_phase;

    assign short_phase = (state == ST_ARMED) && ev.seen && (run_len < thresh);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT_EDGE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = ST_WAIT_EDGE;
        end else begin
            unique case (state)
                ST_WAIT_EDGE: if (ev.seen)     state_nxt = ST_ARMED;
                ST_ARMED:     if (short_phase) state_nxt = ST_TRIPPED;
                ST_TRIPPED:   state_nxt = ST_TRIPPED;
                default:      state_nxt = ST_WAIT_EDGE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag  <= 1'b0;
            level <= 1'b0;
            len   <= '0;
        end else if (short_phase) begin
            flag  <= 1'b1;
            level <= ev.level;
            len   <= run_len;
        end
    end
endmodule

// File: rtl/runt_pulse_monitor.sv
`timescale 1ns/1ps
module runt_pulse_monitor
    import rpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             mon_clk,
    input  logic [CNT_W-1:0] min_ticks,
    input  logic             clr,
    output logic             runt_flag,
    output logic             runt_level,
    output logic [CNT_W-1:0] runt_len
);
    logic             mon_sync;
    phase_end_t       phase_ev;
    logic [CNT_W-1:0] phase_len;

    rpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (ref_clk),
        .rst (rst),
        .d   (mon_clk),
        .q   (mon_sync)
    );

    rpm_phase_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (ref_clk),
        .rst     (rst),
        .level   (mon_sync),
        .ev      (phase_ev),
        .run_len (phase_len)
    );

    rpm_capture_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (ref_clk),
        .rst     (rst),
        .clr     (clr),
        .ev      (phase_ev),
        .run_len (phase_len),
        .thresh  (min_ticks),
        .flag    (runt_flag),
        .level   (runt_level),
        .len     (runt_len)
    );
endmodule

// File: rtl/rpm_checker.sv
`timescale 1ns/1ps
module rpm_checker #(
    parameter int CNT_W = 8
) (
    input logic             ref_clk,
    input logic             rst,
    input logic             clr,
    input logic [CNT_W-1:0] min_ticks,
    input logic             runt_flag,
    input logic             runt_level,
    input logic [CNT_W-1:0] runt_len
);
    // R1: outputs are zero whenever no violation is held
    p_idle_zero_r1: assert property (@(posedge ref_clk) disable iff (rst)
        !runt_flag |-> (runt_len == '0) && !runt_level);

    // R3: a held violation always reports a non-zero length
    p_len_nonzero_r3: assert property (@(posedge ref_clk) disable iff (rst)
        runt_flag |-> (runt_len != '0));

    // R5: a new flag reports a length strictly below the minimum that applied
    p_below_min_r5: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(runt_flag) |-> (runt_len < $past(min_ticks)));

    // R7: flag stays high until clear
    p_sticky_r7: assert property (@(posedge ref_clk) disable iff (rst)
        (runt_flag && !clr) |=> runt_flag);

    // R7: captured details are frozen while the flag is held
    p_frozen_r7: assert property (@(posedge ref_clk) disable iff (rst)
        (runt_flag && !clr) |=> ($stable(runt_level) && $stable(runt_len)));

    // R8: clear drops the flag one edge later
    p_clear_r8: assert property (@(posedge ref_clk) disable iff (rst)
        clr |=> !runt_flag);
endmodule

bind runt_pulse_monitor rpm_checker #(.CNT_W(CNT_W)) u_rpm_checker (
    .ref_clk    (ref_clk),
    .rst        (rst),
    .clr        (clr),
    .min_ticks  (min_ticks),
    .runt_flag  (runt_flag),
    .runt_level (runt_level),
    .runt_len   (runt_len)
);

// File: tb/runt_pulse_monitor_bench.sv
`timescale 1ns/1ps
module runt_pulse_monitor_bench;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mon = 1'b0;
    logic             clr = 1'b0;
    logic [CNT_W-1:0] thresh = 8'd5;
    logic             runt_flag;
    logic             runt_level;
    logic [CNT_W-1:0] runt_len;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    runt_pulse_monitor #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_runt_pulse_monitor (
        .ref_clk    (clk),
        .rst        (rst),
        .mon_clk    (mon),
        .min_ticks  (thresh),
        .clr        (clr),
        .runt_flag  (runt_flag),
        .runt_level (runt_level),
        .runt_len   (runt_len)
    );

    // ---------------- behavioural reference model ----------------
    bit hist[$];          // last three samples of mon, oldest first
    int m_len   = 0;      // ticks in current synchronized phase
    bit m_known = 0;      // a phase start has been observed
    bit m_flag  = 0;
    bit m_lvl   = 0;
    int m_rlen  = 0;
    bit m_edge;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_len = 0; m_known = 0; m_flag = 0; m_lvl = 0; m_rlen = 0;
        end else begin
            m_edge = (hist[1] != hist[0]);
            if (clr) begin
                m_known = 0; m_flag = 0; m_lvl = 0; m_rlen = 0;
            end else if (m_edge) begin
                if (!m_known) m_known = 1;
                else if (!m_flag && m_len < int'(thresh)) begin
                    m_flag = 1; m_lvl = hist[0]; m_rlen = m_len;
                end
            end
            if (m_edge) m_len = 1;
            else if (m_len < CMAX) m_len = m_len + 1;
            hist.push_back(mon);
            hist.delete(0);
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (runt_flag !== m_flag || runt_level !== m_lvl || int'(runt_len) != m_rlen) begin
                errors++;
                $display("FAIL R2 model cycle at %0t: actual flag=%0d lvl=%0d len=%0d expected flag=%0d lvl=%0d len=%0d",
                         $time, runt_flag, runt_level, runt_len, m_flag, m_lvl, m_rlen);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic expect_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input bit v, input int n);
        mon = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge clk);
        expect_eq("R1 flag in reset", int'(runt_flag), 0);
        expect_eq("R1 len in reset", int'(runt_len), 0);
        expect_eq("R1 level in reset", int'(runt_level), 0);
        rst = 1'b0;

        // R6: very short first phase after reset is ignored
        hold(0, 1); hold(1, 8); hold(0, 8); hold(1, 8);
        expect_eq("R6 first phase ignored", int'(runt_flag), 0);

        // R5: phases equal to the minimum do not trip
        hold(0, 5); hold(1, 5); hold(0, 8);
        expect_eq("R5 equal length no trip", int'(runt_flag), 0);

        // R3 and R2: short high phase, exact latency
        hold(1, 4);
        mon = 1'b0;
        @(negedge clk); expect_eq("R2 flag after t", int'(runt_flag), 0);
        @(negedge clk); expect_eq("R2 flag after t+1", int'(runt_flag), 0);
        @(negedge clk); expect_eq("R2 flag after t+2", int'(runt_flag), 1);
        expect_eq("R3 level high", int'(runt_level), 1);
        expect_eq("R3 length", int'(runt_len), 4);
        hold(0, 5);

        // R7: later violation does not overwrite
        hold(1, 8); hold(0, 1); hold(1, 8);
        expect_eq("R7 flag held", int'(runt_flag), 1);
        expect_eq("R7 level kept", int'(runt_level), 1);
        expect_eq("R7 length kept", int'(runt_len), 4);

        // R8: clear
        thresh = 8'd20;
        pulse_clear();
        expect_eq("R8 flag cleared", int'(runt_flag), 0);
        expect_eq("R8 len cleared", int'(runt_len), 0);
        expect_eq("R8 level cleared", int'(runt_level), 0);

        // R6: phase in progress at clear is ignored
        hold(1, 2); hold(0, 25); hold(1, 25);
        expect_eq("R6 phase at clear ignored", int'(runt_flag), 0);

        // R4: short low phase
        thresh = 8'd5;
        hold(0, 2); hold(1, 8);
        expect_eq("R4 flag", int'(runt_flag), 1);
        expect_eq("R4 level low", int'(runt_level), 0);
        expect_eq("R4 length", int'(runt_len), 2);
        pulse_clear();

        // R9: saturation
        thresh = 8'd255;
        hold(1, 3); hold(0, 300); hold(1, 300); hold(0, 300);
        expect_eq("R9 saturated no trip", int'(runt_flag), 0);
        hold(1, 254); hold(0, 8);
        expect_eq("R9 near max trips", int'(runt_flag), 1);
        expect_eq("R9 near max length", int'(runt_len), 254);
        pulse_clear();

        // R10: zero minimum never trips
        thresh = 8'd0;
        for (int i = 0; i < 12; i++) hold(i[0], 1);
        hold(0, 8);
        expect_eq("R10 zero minimum", int'(runt_flag), 0);

        finish_run();
    end
endmodule